// File: doc/BRIEF.md
# Window-Coded Atomic Register Bridge

This block sits between a simple memory-mapped CPU bus and a small bank of 32-bit control registers that it keeps inside itself. The address of an access chooses both the target register and the kind of update. Six address windows exist. One gives plain reads and writes. Two give bit set and bit clear. Three give masked writes of a 4-, 8- or 16-bit field. In the masked windows a single bus word carries both the mask and the new data. Those windows spread their addresses so that every field of a register has an address of its own.

Set, clear and masked updates are done inside the bridge as a read-modify-write that cannot be split. Software can therefore change one field without a read, without a lock, and without a race against other code that touches the same register. An access that the bridge cannot honour still completes its handshake. It is answered with a one-cycle error flag and has no other effect.

Top module: `alias_rmw_bridge`

## Requirements
- R1: Address decode uses these windows. The plain window runs from 0x000 to 0x07F, the set window from 0x080 to 0x0FF and the clear window from 0x100 to 0x17F, with register i at +4i in each. The masked windows are 4-bit at 0x200, 8-bit at 0x300 and 16-bit at 0x400, with register i at +8i in each. Range 0x180–0x1FF is unmapped. An access to an unmapped address, or to a register index of NREG or more, is an error.
- R2: In the plain window a write changes only the addressed lanes. The size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. The operand is taken right-justified from bus_wdata and placed at byte lane addr[1:0]. For example, an 8-bit write at +2 changes bits 23:16.
- R3: Reads are allowed only in the plain window, with size 8 or 16. The result is right-justified and zero-extended in bus_rdata. The upper halfword is read at +2 and the top byte at +3.
- R4: A set-window write ORs the lane-placed operand into the register and leaves all other bits unchanged.
- R5: A clear-window write clears every register bit where the lane-placed operand is 1 and leaves all other bits unchanged.
- R6: A 16-bit masked write is a 32-bit access. The mask is in bits 31:16 and the data in bits 15:0. Offset +0 selects register bits 15:0 and +4 selects bits 31:16. Each bit set in the mask takes the matching data bit.
- R7: An 8-bit masked write is a 16-bit access. The mask is in bits 15:8 and the data in bits 7:0. Register byte n is at +2n.
- R8: A 4-bit masked write is an 8-bit access. The mask is in bits 7:4 and the data in bits 3:0. Register nibble n is at +n.
- R9: The bridge accepts a request at a clock edge where bus_valid is high and it is idle. bus_ready then pulses for one cycle, starting 1 cycle after acceptance for plain or error accesses and 2 cycles after acceptance for set, clear and masked writes. No request is accepted while one is in flight.
- R10: These accesses raise bus_err together with bus_ready: a masked access of the wrong size, a read outside the plain window, a 32-bit read, a size code of 3, and a plain, set or clear access not aligned to its size. Such an access changes no register and returns zero data.
- R11: An active-low synchronous reset clears every register and holds bus_ready and bus_err low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Request present; held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| bus_addr | input | AW | Byte offset within the bridge |
| bus_wdata | input | 32 | Write operand, or packed mask and data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_err | output | 1 | Error flag, valid with bus_ready |

## Verification
The bench targets how fields are placed in each masked window: the top nibble at +7, the top byte at +6 and the high half at +4. A shift that is off by one lane would corrupt the next field. It also checks that a partial mask, such as 0x0F over byte 3, keeps the unmasked bits. A merge that ignored the mask would overwrite the whole field.

Error cases are followed by reads of the register they address, to show that nothing changed. These cases are a wrong-size masked access, a misaligned plain write and an index past the bank; a design that decoded without checking would quietly write a register. Latency is measured on every access, so a set or clear done in one cycle, or a plain write that stalls, shows up. A reset in the middle of the run must clear registers that hold values.

// File: rtl/alias_bridge_pkg.sv
package alias_bridge_pkg;
  localparam int DW    = 32;
  localparam int IDX_W = 5;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  typedef enum logic [2:0] {
    WIN_DIR, WIN_SET, WIN_CLR, WIN_M4, WIN_M8, WIN_M16, WIN_NONE
  } win_e;

  typedef struct packed {
    logic [DW-1:0] m;
    logic [DW-1:0] d;
  } md_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    return 32'h0000_00FF;
      SZ_H:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Operand placed at its byte lane
  function automatic logic [DW-1:0] lane_place(input logic [1:0] sz,
                                               input logic [1:0] boff,
                                               input logic [DW-1:0] wd);
    return (wd & size_mask(sz)) << {boff, 3'b000};
  endfunction

  // Every write kind reduces to a (mask, data) pair
  function automatic md_t field_md(input win_e win, input logic [1:0] sz,
                                   input logic [2:0] off,
                                   input logic [DW-1:0] wd);
    md_t r;
    r.m = '0;
    r.d = '0;
    case (win)
      WIN_DIR: begin
        r.m = size_mask(sz) << {off[1:0], 3'b000};
        r.d = lane_place(sz, off[1:0], wd);
      end
      WIN_SET: begin
        r.m = lane_place(sz, off[1:0], wd);
        r.d = '1;
      end
      WIN_CLR: begin
        r.m = lane_place(sz, off[1:0], wd);
        r.d = '0;
      end
      WIN_M16: begin
        r.m = {16'h0, wd[31:16]} << {off[2], 4'b0000};
        r.d = {16'h0, wd[15:0]}  << {off[2], 4'b0000};
      end
      WIN_M8: begin
        r.m = {24'h0, wd[15:8]} << {off[2:1], 3'b000};
        r.d = {24'h0, wd[7:0]}  << {off[2:1], 3'b000};
      end
      WIN_M4: begin
        r.m = {28'h0, wd[7:4]} << {off[2:0], 2'b00};
        r.d = {28'h0, wd[3:0]} << {off[2:0], 2'b00};
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [DW-1:0] merge_bits(input logic [DW-1:0] old,
                                               input md_t md);
    return (old & ~md.m) | (md.d & md.m);
  endfunction

  function automatic logic [DW-1:0] read_pick(input logic [1:0] sz,
                                              input logic [1:0] boff,
                                              input logic [DW-1:0] val);
    return (val >> {boff, 3'b000}) & size_mask(sz);
  endfunction
endpackage

// File: rtl/alias_addr_decode.sv
module alias_addr_decode
  import alias_bridge_pkg::*;
#(
  parameter int AW   = 11,
  parameter int NREG = 8
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  input  logic             write,
  output win_e             win,
  output logic [IDX_W-1:0] idx,
  output logic [2:0]       off,
  output logic             err
);
  logic hi_ok;
  logic masked;
  logic align_ok;
  logic size_ok;

  generate
    if (AW > 11) begin : g_hi
      assign hi_ok = (addr[AW-1:11] == '0);
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    case (addr[10:8])
      3'd0:    win = addr[7] ? WIN_SET : WIN_DIR;
      3'd1:    win = addr[7] ? WIN_NONE : WIN_CLR;
      3'd2:    win = WIN_M4;
      3'd3:    win = WIN_M8;
      3'd4:    win = WIN_M16;
      default: win = WIN_NONE;
    endcase
    if (!hi_ok) win = WIN_NONE;
  end

  assign masked = (win == WIN_M4) || (win == WIN_M8) || (win == WIN_M16);

  always_comb begin
    if (masked) begin
      idx = addr[7:3];
      off = addr[2:0];
    end else begin
      idx = addr[6:2];
      off = {1'b0, addr[1:0]};
    end
  end

  always_comb begin
    size_ok  = 1'b1;
    align_ok = 1'b1;
    case (win)
      WIN_M16: begin
        size_ok  = (size == SZ_W);
        align_ok = (off[1:0] == 2'b00);
      end
      WIN_M8: begin
        size_ok  = (size == SZ_H);
        align_ok = !off[0];
      end
      WIN_M4:  size_ok = (size == SZ_B);
      default: begin
        size_ok = (size != 2'd3);
        if (size == SZ_H) align_ok = !off[0];
        if (size == SZ_W) align_ok = (off[1:0] == 2'b00);
      end
    endcase
  end

  assign err = (win == WIN_NONE)
            || (int'(idx) >= NREG)
            || !size_ok
            || !align_ok
            || (!write && (win != WIN_DIR))
            || (!write && (size == SZ_W));
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_bridge_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DW-1:0]    wval,
  input  logic [IDX_W-1:0] ridx,
  output logic [DW-1:0]    rval
);
  logic [DW-1:0] regs [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)                         regs[g] <= '0;
        else if (we && (int'(widx) == g))   regs[g] <= wval;
      end
    end
  endgenerate

  always_comb begin
    rval = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(ridx) == i) rval = regs[i];
  end
endmodule

// File: rtl/alias_rmw_bridge.sv
module alias_rmw_bridge
  import alias_bridge_pkg::*;
#(
  parameter int AW   = 11,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ready,
  output logic [31:0]   bus_rdata,
  output logic          bus_err
);
  typedef enum logic [1:0] {S_IDLE, S_RMW, S_RESP} st_e;

  st_e              state;
  win_e             dec_win;
  logic [IDX_W-1:0] dec_idx;
  logic [2:0]       dec_off;
  logic             dec_err;
  md_t              cur_md, hold_md;
  logic [IDX_W-1:0] hold_idx;
  logic [DW-1:0]    old_q, rval, wval, rdata_q;
  logic             err_q;

  // Named events for the checker
  logic             acc_fire, rmw_start, dir_write, wr_en;
  logic [IDX_W-1:0] wr_idx;

  alias_addr_decode #(.AW(AW), .NREG(NREG)) u_dec (
    .addr (bus_addr),
    .size (bus_size),
    .write(bus_write),
    .win  (dec_win),
    .idx  (dec_idx),
    .off  (dec_off),
    .err  (dec_err)
  );

  assign cur_md    = field_md(dec_win, bus_size, dec_off, bus_wdata);
  assign acc_fire  = (state == S_IDLE) && bus_valid;
  assign dir_write = acc_fire && !dec_err && bus_write && (dec_win == WIN_DIR);
  assign rmw_start = acc_fire && !dec_err && bus_write && (dec_win != WIN_DIR);
  assign wr_en     = dir_write || (state == S_RMW);
  assign wr_idx    = (state == S_RMW) ? hold_idx : dec_idx;
  assign wval      = (state == S_RMW) ? merge_bits(old_q, hold_md)
                                      : merge_bits(rval, cur_md);

  alias_reg_bank #(.NREG(NREG)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_en),
    .widx (wr_idx),
    .wval (wval),
    .ridx (dec_idx),
    .rval (rval)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      err_q    <= 1'b0;
      rdata_q  <= '0;
      old_q    <= '0;
      hold_idx <= '0;
      hold_md  <= '0;
    end else begin
      case (state)
        S_IDLE: if (acc_fire) begin
          err_q   <= dec_err;
          rdata_q <= '0;
          if (dec_err) begin
            state <= S_RESP;
          end else if (!bus_write) begin
            rdata_q <= read_pick(bus_size, dec_off[1:0], rval);
            state   <= S_RESP;
          end else if (dec_win == WIN_DIR) begin
            state <= S_RESP;
          end else begin
            old_q    <= rval;
            hold_idx <= dec_idx;
            hold_md  <= cur_md;
            state    <= S_RMW;
          end
        end
        S_RMW:   state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_ready = (state == S_RESP);
  assign bus_err   = bus_ready && err_q;
  assign bus_rdata = bus_ready ? rdata_q : '0;
endmodule

// File: rtl/alias_bridge_chk.sv
module alias_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_ready,
  input logic        bus_err,
  input logic [31:0] bus_rdata,
  input logic        acc_fire,
  input logic        rmw_start,
  input logic        dec_err,
  input logic        wr_en
);
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  a_r9_rmw_write_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |=> (wr_en && !bus_ready));

  a_r9_rmw_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rmw_start |-> ##2 bus_ready);

  a_r9_plain_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !rmw_start) |=> bus_ready);

  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !acc_fire);

  a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && dec_err) |-> !wr_en);

  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_ready && bus_rdata == 32'h0));
endmodule

bind alias_rmw_bridge alias_bridge_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_ready(bus_ready),
  .bus_err  (bus_err),
  .bus_rdata(bus_rdata),
  .acc_fire (acc_fire),
  .rmw_start(rmw_start),
  .dec_err  (dec_err),
  .wr_en    (wr_en)
);

// File: tb/alias_rmw_bridge_bench.sv
`timescale 1ns/1ps
module alias_rmw_bridge_bench;
  localparam int AW = 11;
  localparam int NREG = 8;
  localparam int NV = 50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_size = 2'd0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_ready;
  logic [31:0]   bus_rdata;
  logic          bus_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alias_rmw_bridge #(.AW(AW), .NREG(NREG)) u_alias_rmw_bridge (.*);

  // {req[4], write, size[2], addr[11], wdata[32], exp_rdata[16], exp_err, exp_lat[2]}
  localparam logic [68:0] VEC [NV] = '{
    {4'd2, 1'b1,2'd2,11'h004,32'h12345678,16'h0000,1'b0,2'd1}, // R2 word write
    {4'd3, 1'b0,2'd1,11'h004,32'h0,16'h5678,1'b0,2'd1},        // R3
    {4'd3, 1'b0,2'd1,11'h006,32'h0,16'h1234,1'b0,2'd1},        // R3 high half
    {4'd3, 1'b0,2'd0,11'h007,32'h0,16'h0012,1'b0,2'd1},        // R3 top byte
    {4'd2, 1'b1,2'd0,11'h005,32'h000000AB,16'h0,1'b0,2'd1},    // R2 byte lane 1
    {4'd2, 1'b0,2'd1,11'h004,32'h0,16'hAB78,1'b0,2'd1},
    {4'd2, 1'b1,2'd1,11'h006,32'h0000CAFE,16'h0,1'b0,2'd1},    // R2 half lane
    {4'd2, 1'b0,2'd1,11'h006,32'h0,16'hCAFE,1'b0,2'd1},
    {4'd4, 1'b1,2'd2,11'h084,32'h00000007,16'h0,1'b0,2'd2},    // R4 set word
    {4'd4, 1'b0,2'd0,11'h004,32'h0,16'h007F,1'b0,2'd1},
    {4'd4, 1'b1,2'd0,11'h087,32'h00000001,16'h0,1'b0,2'd2},    // R4 set byte 3
    {4'd4, 1'b0,2'd0,11'h007,32'h0,16'h00CB,1'b0,2'd1},
    {4'd5, 1'b1,2'd1,11'h106,32'h000000FE,16'h0,1'b0,2'd2},    // R5 clear half
    {4'd5, 1'b0,2'd1,11'h006,32'h0,16'hCB00,1'b0,2'd1},
    {4'd5, 1'b0,2'd1,11'h004,32'h0,16'hAB7F,1'b0,2'd1},
    {4'd5, 1'b1,2'd2,11'h104,32'hFFFFFFFF,16'h0,1'b0,2'd2},    // R5 clear all
    {4'd5, 1'b0,2'd1,11'h004,32'h0,16'h0000,1'b0,2'd1},
    {4'd5, 1'b0,2'd1,11'h006,32'h0,16'h0000,1'b0,2'd1},
    {4'd6, 1'b1,2'd2,11'h410,32'hFFFF5555,16'h0,1'b0,2'd2},    // R6 low half
    {4'd6, 1'b1,2'd2,11'h414,32'h01FF01AA,16'h0,1'b0,2'd2},    // R6 high half
    {4'd6, 1'b0,2'd1,11'h00A,32'h0,16'h01AA,1'b0,2'd1},
    {4'd6, 1'b0,2'd1,11'h008,32'h0,16'h5555,1'b0,2'd1},
    {4'd7, 1'b1,2'd1,11'h312,32'h0000FF11,16'h0,1'b0,2'd2},    // R7 byte 1
    {4'd7, 1'b1,2'd1,11'h316,32'h00000F33,16'h0,1'b0,2'd2},    // R7 byte 3 partial
    {4'd7, 1'b0,2'd0,11'h00B,32'h0,16'h0003,1'b0,2'd1},
    {4'd7, 1'b0,2'd0,11'h009,32'h0,16'h0011,1'b0,2'd1},
    {4'd8, 1'b1,2'd0,11'h210,32'h000000F7,16'h0,1'b0,2'd2},    // R8 nibble 0
    {4'd8, 1'b1,2'd0,11'h211,32'h000000F4,16'h0,1'b0,2'd2},    // R8 nibble 1
    {4'd8, 1'b1,2'd0,11'h217,32'h00000039,16'h0,1'b0,2'd2},    // R8 nibble 7
    {4'd8, 1'b0,2'd0,11'h008,32'h0,16'h0047,1'b0,2'd1},
    {4'd8, 1'b0,2'd0,11'h00B,32'h0,16'h0013,1'b0,2'd1},
    {4'd1, 1'b1,2'd2,11'h01C,32'hA5A50F0F,16'h0,1'b0,2'd1},    // R1 last register
    {4'd1, 1'b0,2'd1,11'h01E,32'h0,16'hA5A5,1'b0,2'd1},
    {4'd6, 1'b1,2'd2,11'h43C,32'hFF001200,16'h0,1'b0,2'd2},    // R6 last reg high
    {4'd6, 1'b0,2'd1,11'h01E,32'h0,16'h12A5,1'b0,2'd1},
    {4'd6, 1'b0,2'd1,11'h01C,32'h0,16'h0F0F,1'b0,2'd1},
    {4'd10,1'b1,2'd1,11'h410,32'h00000000,16'h0,1'b1,2'd1},    // R10 m16 wrong size
    {4'd10,1'b0,2'd1,11'h008,32'h0,16'h1147,1'b0,2'd1},
    {4'd10,1'b0,2'd1,11'h084,32'h0,16'h0000,1'b1,2'd1},        // R10 read in set win
    {4'd10,1'b0,2'd2,11'h008,32'h0,16'h0000,1'b1,2'd1},        // R10 word read
    {4'd1, 1'b1,2'd0,11'h1A0,32'h000000FF,16'h0,1'b1,2'd1},    // R1 unmapped gap
    {4'd1, 1'b1,2'd2,11'h020,32'hFFFFFFFF,16'h0,1'b1,2'd1},    // R1 index == NREG
    {4'd1, 1'b1,2'd2,11'h440,32'hFFFFFFFF,16'h0,1'b1,2'd1},    // R1 m16 index == NREG
    {4'd10,1'b1,2'd0,11'h312,32'h000000FF,16'h0,1'b1,2'd1},    // R10 m8 wrong size
    {4'd10,1'b1,2'd1,11'h210,32'h000000FF,16'h0,1'b1,2'd1},    // R10 m4 wrong size
    {4'd10,1'b0,2'd0,11'h009,32'h0,16'h0011,1'b0,2'd1},
    {4'd10,1'b1,2'd1,11'h005,32'h0000FFFF,16'h0,1'b1,2'd1},    // R10 misaligned
    {4'd10,1'b1,2'd3,11'h000,32'hFFFFFFFF,16'h0,1'b1,2'd1},    // R10 size code 3
    {4'd10,1'b0,2'd1,11'h004,32'h0,16'h0000,1'b0,2'd1},
    {4'd10,1'b0,2'd1,11'h000,32'h0,16'h0000,1'b0,2'd1}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [1:0] sz,
                        input logic [AW-1:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_size = sz; bus_addr = a; bus_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ready && lat < 20);
    rd = bus_rdata;
    er = bus_err;
    bus_valid = 1'b0;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    int lat;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(11, "ready in reset", {31'h0, bus_ready}, 32'h0);
    check(11, "err in reset", {31'h0, bus_err}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      access(1'b0, 2'd1, AW'(4 * i), 32'h0, rd, er, lat);
      check(11, "reg after reset", rd, 32'h0);
    end

    for (int v = 0; v < NV; v++) begin
      access(VEC[v][64], VEC[v][63:62], VEC[v][61:51], VEC[v][50:19], rd, er, lat);
      check(int'(VEC[v][68:65]), $sformatf("vec %0d rdata", v), rd, {16'h0, VEC[v][18:3]});
      check(int'(VEC[v][68:65]), $sformatf("vec %0d err", v), {31'h0, er}, {31'h0, VEC[v][2]});
      check(9, $sformatf("vec %0d latency", v), lat, {30'h0, VEC[v][1:0]});
    end

    // R9: ready lasts exactly one cycle
    access(1'b0, 2'd1, 11'h01C, 32'h0, rd, er, lat);
    @(negedge clk);
    check(9, "ready pulse width", {31'h0, bus_ready}, 32'h0);

    // R11: reset mid-run clears registers that hold data
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(11, "ready during reset", {31'h0, bus_ready}, 32'h0);
    rst_n = 1'b1;
    access(1'b0, 2'd1, 11'h00A, 32'h0, rd, er, lat);
    check(11, "reg2 after reset", rd, 32'h0);
    access(1'b0, 2'd1, 11'h01E, 32'h0, rd, er, lat);
    check(11, "reg7 after reset", rd, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule